// File: doc/BRIEF.md
# Periodic Battery-Low Check Sequencer

This block decides when a backup battery is tested and holds the result. An external comparator reports whether the battery is above its minimum level. The block asks that comparator for a measurement whenever main power becomes valid. While power stays valid it asks again after every `INTERVAL_TICKS` clock cycles.

A check has three steps. First the block raises a sample request. It then waits `SETTLE_TICKS` cycles so the comparator can settle. Finally it reads the battery-good input and loads the verdict into a sticky flag. The flag drives the active-low `bat_low_n` output. A low battery leaves the flag set until a later check passes. The flag keeps its value while power is invalid, because no checks run in that state.

The sample request is a valid/ready handshake, with `smp_req` as valid and `smp_ack` as ready:
- With `USE_ACK=1`, `smp_req` stays high until the first clock edge at which `smp_ack` is high. That edge is the acceptance edge.
- With `USE_ACK=0`, `smp_ack` is ignored. The request lasts one cycle and is accepted at the edge that ends it.

Top module: `bat_check_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with `pwr_ok` low, `bat_low_n` is 1 and `smp_req` is 0.
- R2: A check starts on the first clock edge at which `pwr_ok` is sampled high after having been low, or after reset. `smp_req` is high in the cycle that follows this edge.
- R3: With `USE_ACK=1`, `smp_req` stays high while `smp_ack` is low and power is valid. It is low in the cycle after the acceptance edge.
- R4: The verdict is sampled at the clock edge `SETTLE_TICKS` cycles after the acceptance edge. From then on, `bat_low_n` is 0 if `bat_good` was 0 at that edge, and 1 if it was 1.
- R5: While `pwr_ok` stays high, a new check starts every `INTERVAL_TICKS` cycles. This spacing is counted from the most recent power-up check, so the count restarts at every power-up.
- R6: Between checks, changes on `bat_good` have no effect on `bat_low_n`.
- R7: While `pwr_ok` is low, no check starts and `bat_low_n` keeps its value. If power drops during a check, the check ends without changing `bat_low_n`.
- R8: A synchronous reset sets `bat_low_n` to 1, whatever its earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_ok | input | 1 | Main power valid |
| bat_good | input | 1 | Comparator result, 1 = battery above the minimum level |
| smp_ack | input | 1 | Ready for the sample request (used when USE_ACK=1) |
| smp_req | output | 1 | Sample request to the comparator (valid) |
| bat_low_n | output | 1 | Battery-low flag, active low |

## Verification
The bench builds the block with `INTERVAL_TICKS=40`, `SETTLE_TICKS=3` and `USE_ACK=1`.
- The short interval makes several periodic checks, and their exact spacing, reachable in a few hundred cycles.
- The three-cycle settle window lets each test show the flag unchanged one edge before the sample point and updated at it.
- Enabling the handshake exposes back-pressure on the request.
- A power loss placed in the middle of an interval shows that the next spacing is measured from the power-up check.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_REQ,
    PH_SETTLE
  } probe_ph_t;
endpackage

// File: rtl/bchk_sched.sv
module bchk_sched #(
  parameter longint unsigned INTERVAL_TICKS = 64'd2831155200
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  output logic start
);
  localparam int CW = $clog2(INTERVAL_TICKS + 1);

  logic          pwr_q;
  logic [CW-1:0] tick;
  logic          rise;
  logic          wrap;

  assign rise  = pwr_ok & ~pwr_q;
  assign wrap  = pwr_ok && (tick == CW'(INTERVAL_TICKS - 1));
  assign start = rise | wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= 1'b0;
      tick  <= '0;
    end else begin
      pwr_q <= pwr_ok;
      if (pwr_ok) begin
        if (rise || wrap) tick <= '0;
        else              tick <= tick + CW'(1);
      end
    end
  end

  // R2
  powerup_start_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_ok && !$past(pwr_ok)) |-> start);
endmodule

// File: rtl/bchk_probe.sv
module bchk_probe
  import bchk_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 16,
  parameter bit          USE_ACK      = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic start,
  input  logic ack,
  input  logic bat_good,
  output logic req,
  output logic upd,
  output logic fail
);
  localparam int SW = $clog2(SETTLE_TICKS + 1);

  probe_ph_t     ph;
  logic [SW-1:0] scnt;
  logic          take;
  logic          settle_done;

  generate
    if (USE_ACK) begin : g_hs
      assign take = ack;
    end else begin : g_pulse
      assign take = 1'b1;
    end
  endgenerate

  assign req         = (ph == PH_REQ);
  assign settle_done = (ph == PH_SETTLE) && (scnt == SW'(SETTLE_TICKS - 1));
  assign upd         = settle_done && pwr_ok;
  assign fail        = ~bat_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      scnt <= '0;
    end else if (!pwr_ok) begin
      ph   <= PH_IDLE;
      scnt <= '0;
    end else begin
      case (ph)
        PH_IDLE:   if (start) ph <= PH_REQ;
        PH_REQ:    if (take) begin
                     ph   <= PH_SETTLE;
                     scnt <= '0;
                   end
        PH_SETTLE: if (settle_done) ph <= PH_IDLE;
                   else             scnt <= scnt + SW'(1);
        default:   ph <= PH_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !take && pwr_ok) |=> req);

  // R7
  no_req_unpowered_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> !req);
endmodule

// File: rtl/bchk_flag.sv
module bchk_flag (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic fail,
  output logic low_n
);
  logic low;

  always_ff @(posedge clk) begin
    if (rst)      low <= 1'b0;
    else if (upd) low <= fail;
  end

  assign low_n = ~low;
endmodule

// File: rtl/bat_check_seq.sv
module bat_check_seq #(
  parameter longint unsigned INTERVAL_TICKS = 64'd2831155200,
  parameter int unsigned     SETTLE_TICKS   = 16,
  parameter bit              USE_ACK        = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic bat_good,
  input  logic smp_ack,
  output logic smp_req,
  output logic bat_low_n
);
  logic start;
  logic upd;
  logic fail;

  bchk_sched #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_sched (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .start(start)
  );

  bchk_probe #(.SETTLE_TICKS(SETTLE_TICKS), .USE_ACK(USE_ACK)) u_probe (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .start(start), .ack(smp_ack),
    .bat_good(bat_good), .req(smp_req), .upd(upd), .fail(fail)
  );

  bchk_flag u_flag (
    .clk(clk), .rst(rst), .upd(upd), .fail(fail), .low_n(bat_low_n)
  );

  // R7
  flag_needs_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    (bat_low_n != $past(bat_low_n)) |-> $past(pwr_ok));
endmodule

// File: tb/test_bat_check_seq.sv
module test_bat_check_seq;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 40;
  localparam int SETTLE     = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0;
  logic bat_good = 1'b1;
  logic smp_ack = 1'b0;
  logic smp_req;
  logic bat_low_n;

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;
  bit done = 1'b0;

  bat_check_seq #(
    .INTERVAL_TICKS(INTERVAL), .SETTLE_TICKS(SETTLE), .USE_ACK(1'b1)
  ) i_bat_check_seq (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .bat_good(bat_good),
    .smp_ack(smp_ack), .smp_req(smp_req), .bat_low_n(bat_low_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_req(input string tag, output int at);
    at = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (smp_req) begin
        at = cyc;
        break;
      end
    end
    check({tag, " request seen"}, (at >= 0) ? 1 : 0, 1);
  endtask

  // Called at a negedge with smp_req high: hold back, accept, watch the settle window.
  task automatic do_ack(input int hold, input int exp_old, input int exp_new, input string tag);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check({tag, " R3 request held"}, smp_req, 1);
    end
    smp_ack = 1'b1;
    @(negedge clk);
    smp_ack = 1'b0;
    check({tag, " R3 request dropped after accept"}, smp_req, 0);
    repeat (SETTLE - 1) @(negedge clk);
    check({tag, " R4 flag before sample"}, bat_low_n, exp_old);
    @(negedge clk);
    check({tag, " R4 flag after sample"}, bat_low_n, exp_new);
  endtask

  task automatic t_reset();
    int seen;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flag in reset", bat_low_n, 1);
    check("R1 request in reset", smp_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flag after reset", bat_low_n, 1);
    check("R1 request after reset", smp_req, 0);
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (smp_req) seen = 1;
    end
    check("R7 no request while unpowered", seen, 0);
  endtask

  int t0, t1, t2, t3, t4, t5;

  task automatic t_powerup_bad();
    bat_good = 1'b0;
    pwr_ok   = 1'b1;
    @(negedge clk);
    t0 = cyc;
    check("R2 request after power-up edge", smp_req, 1);
    do_ack(3, 1, 0, "powerup bad");
  endtask

  task automatic t_sticky_periodic();
    int bad;
    bat_good = 1'b1;
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (bat_low_n != 0) bad = 1;
    end
    check("R6 flag sticky while bat_good high", bad, 0);
    wait_req("periodic pass", t1);
    check("R5 interval spacing 1", t1 - t0, INTERVAL);
    do_ack(0, 0, 1, "periodic pass");
  endtask

  task automatic t_periodic_bad();
    int bad;
    bat_good = 1'b0;
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (bat_low_n != 1) bad = 1;
    end
    check("R6 flag sticky while bat_good low", bad, 0);
    wait_req("periodic bad", t2);
    check("R5 interval spacing 2", t2 - t1, INTERVAL);
    do_ack(1, 1, 0, "periodic bad");
  endtask

  task automatic t_power_drop();
    int seen;
    repeat (7) @(negedge clk);
    pwr_ok   = 1'b0;
    bat_good = 1'b1;
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (smp_req) seen = 1;
    end
    check("R7 no request during power loss", seen, 0);
    check("R7 flag kept during power loss", bat_low_n, 0);
    pwr_ok = 1'b1;
    @(negedge clk);
    t3 = cyc;
    check("R2 request after power return", smp_req, 1);
    do_ack(0, 0, 1, "power return");
    wait_req("after power return", t4);
    check("R5 interval restarts at power-up", t4 - t3, INTERVAL);
    do_ack(0, 1, 1, "after power return");
  endtask

  task automatic t_abort();
    bat_good = 1'b0;
    wait_req("abort", t5);
    check("R5 interval spacing 3", t5 - t4, INTERVAL);
    smp_ack = 1'b1;
    @(negedge clk);
    smp_ack = 1'b0;
    @(negedge clk);
    pwr_ok = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 aborted check leaves flag", bat_low_n, 1);
    pwr_ok = 1'b1;
    @(negedge clk);
    check("R2 request after abort power-up", smp_req, 1);
    do_ack(0, 1, 0, "abort repower");
  endtask

  task automatic t_reset_clear();
    bat_good = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 reset clears flag", bat_low_n, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R2 request out of reset with power", smp_req, 1);
    do_ack(0, 1, 1, "post reset");
  endtask

  initial begin
    t_reset();
    t_powerup_bad();
    t_sticky_periodic();
    t_periodic_bad();
    t_power_drop();
    t_abort();
    t_reset_clear();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vecs++;
      errs++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule